// File: doc/BRIEF.md
# Sliding-Window Symbol Belief Cache

This block is the working store of a message-passing symbol detector that handles one check node (one layer) at a time. It keeps the accumulated per-symbol log-likelihood values of a run of `WIN_LEN` consecutive variable nodes in registers. Each node entry packs `NUM_LLR` signed values of `LLR_W` bits. The layer processor reads `NUM_TAPS` entries through taps whose positions in the window are programmable. These positions follow the delays of the nonzero channel coefficients, and they need not be evenly spaced.

The processor returns updated entries for those same taps, possibly a few layers later. Each update is merged into the window in place, so the layers that follow see it at once. Each accepted advance brings in one new node, fetched from the frame memory. The oldest node drops out of the window and is the only one written back to that memory, where the next pass over the frame picks it up.

A frame is `FRAME_LEN` nodes long. On the first pass the nodes enter with all-zero values and the memory is not read. Positions before the first node or after the last node are absent: they read as zero, they ignore updates and they are never written back.

Top module: `llr_window_cache`

## Requirements
- R1: After reset, `busy` and `evict_we` are 0, every bit of `tap_valid` and `tap_data` is 0, and tap k has window position k.
- R2: In a cycle with an accepted advance, `fill_rd` is 1 when the entering node index is below `FRAME_LEN` and the frame is not a first pass. In that case `fill_addr` equals that index, counting up from 0, and `fill_data` is captured at that edge. On a first pass (`first_pass` high when the frame started), `fill_rd` stays 0 and the node enters as zero.
- R3: Window position 0 holds the oldest node. Tap k shows, in the same cycle, the entry of node `next - WIN_LEN + off_k`, where `next` is the number of accepted advances since start. Each accepted advance moves the window by exactly one node.
- R4: A node index below 0 or at or above `FRAME_LEN` is absent. Its tap reads `tap_valid`=0 and `tap_data`=0, and an update aimed at it is dropped. While `busy` is 0 all taps are absent.
- R5: One cycle after an accepted advance whose oldest node is present, `evict_we` is 1 for that cycle, `evict_addr` is the node index and `evict_data` is its entry. That entry includes any update applied in the advance cycle. Consecutive evictions carry consecutive addresses.
- R6: `wb_en[k]` with `wb_lag`=s writes `wb_data` lane k into window position `off_k - s`. The write takes effect before that cycle's shift. s counts the accepted advances from the cycle the taps were read up to the write cycle, not counting the write cycle. s must not exceed `off_k`.
- R7: When an update in a cycle targets the position that a tap reads in that same cycle, that tap shows the new value in that cycle.
- R8: A tap position write (`cfg_we`, `cfg_sel`, `cfg_off`) takes effect from the next cycle only when `busy` is 0 and `cfg_off` < `WIN_LEN`. Otherwise it is ignored.
- R9: `start` while idle raises `busy` on the next cycle with the frame restarted at node 0. `busy` falls after the (`FRAME_LEN`+`WIN_LEN`)-th accepted advance. `start` is ignored while busy, and `adv` is ignored while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Tap position write strobe |
| cfg_sel | input | SEL_W | Tap being configured |
| cfg_off | input | POS_W | New window position for that tap |
| start | input | 1 | Begin a frame pass |
| first_pass | input | 1 | Pass enters nodes as zero, sampled with start |
| adv | input | 1 | Advance the window by one node |
| fill_rd | output | 1 | Frame memory entry consumed this cycle |
| fill_addr | output | ADDR_W | Index of the node entering on the next advance |
| fill_data | input | ENT_W | Frame memory entry at fill_addr |
| evict_we | output | 1 | Departing entry write strobe |
| evict_addr | output | ADDR_W | Departing node index |
| evict_data | output | ENT_W | Departing node entry |
| tap_data | output | NUM_TAPS*ENT_W | Tap entries, lane k at k*ENT_W |
| tap_valid | output | NUM_TAPS | Tap node present |
| wb_en | input | NUM_TAPS | Per-tap update strobe |
| wb_lag | input | LAG_W | Advances since the update's read cycle |
| wb_data | input | NUM_TAPS*ENT_W | Updated entries, lane k at k*ENT_W |
| busy | output | 1 | A frame pass is in progress |

## Verification
Tap values, tap validity, forwarded updates and `fill_rd`/`fill_addr` are combinational on the current window and inputs, so they are due in the same cycle as the stimulus. The bench samples them a quarter period after it drives the inputs, before the edge. The eviction outputs and `busy` are registered and are due one edge after the advance, start or final advance that causes them. The bench compares them one time unit after that edge against its own model, which it updates at the edge. Tap position writes and updates become visible through the taps from the cycle after the edge, and the same pre-edge comparison covers them.

// File: rtl/llrwin_pkg.sv
package llrwin_pkg;
  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_RUN  = 1'b1
  } win_state_e;
endpackage

// File: rtl/llrwin_ctrl.sv
module llrwin_ctrl
  import llrwin_pkg::*;
#(
  parameter int unsigned WIN_LEN   = 60,
  parameter int unsigned FRAME_LEN = 1024,
  parameter int unsigned IDX_W     = 11,
  parameter int unsigned ADDR_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              first_pass,
  input  logic              adv,
  output logic              busy,
  output logic              go,
  output logic              clear,
  output logic              enter_valid,
  output logic              zero_fill,
  output logic              fill_rd,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [ADDR_W-1:0] depart_addr
);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_LEN + WIN_LEN - 1);
  localparam logic [IDX_W-1:0] FRAME_IDX = IDX_W'(FRAME_LEN);
  localparam logic [IDX_W-1:0] WIN_IDX   = IDX_W'(WIN_LEN);

  win_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             first_q, first_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    first_d = first_q;
    clear   = 1'b0;
    go      = 1'b0;
    unique case (state_q)
      WS_IDLE: begin
        if (start) begin
          state_d = WS_RUN;
          idx_d   = '0;
          first_d = first_pass;
          clear   = 1'b1;
        end
      end
      WS_RUN: begin
        if (adv) begin
          go    = 1'b1;
          idx_d = idx_q + 1'b1;
          if (idx_q == LAST_IDX) state_d = WS_IDLE;
        end
      end
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      idx_q   <= '0;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (go || clear) begin
        idx_q   <= idx_d;
        first_q <= first_d;
      end
    end
  end

  assign busy        = (state_q == WS_RUN);
  assign enter_valid = (idx_q < FRAME_IDX);
  assign zero_fill   = first_q;
  assign fill_rd     = go && enter_valid && !first_q;
  assign fill_addr   = idx_q[ADDR_W-1:0];
  assign depart_addr = ADDR_W'(idx_q - WIN_IDX);
endmodule

// File: rtl/llrwin_bank.sv
module llrwin_bank #(
  parameter int unsigned WIN_LEN  = 60,
  parameter int unsigned ENT_W    = 24,
  parameter int unsigned NUM_TAPS = 3,
  parameter int unsigned POS_W    = 6,
  parameter int unsigned ADDR_W   = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      go,
  input  logic                      enter_valid,
  input  logic                      zero_fill,
  input  logic [ENT_W-1:0]          fill_data,
  input  logic [NUM_TAPS-1:0]       wr_en,
  input  logic [NUM_TAPS*POS_W-1:0] wr_pos,
  input  logic [NUM_TAPS*ENT_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]         depart_addr,
  output logic [WIN_LEN*ENT_W-1:0]  slot_flat,
  output logic [WIN_LEN-1:0]        slot_valid,
  output logic                      evict_we,
  output logic [ADDR_W-1:0]         evict_addr,
  output logic [ENT_W-1:0]          evict_data
);
  logic [ENT_W-1:0]   slot_q [WIN_LEN];
  logic [ENT_W-1:0]   slot_d [WIN_LEN];
  logic [ENT_W-1:0]   mrg    [WIN_LEN];
  logic [WIN_LEN-1:0] valid_q, valid_d;
  logic               bank_en;

  // updates land on the pre-shift window position
  for (genvar i = 0; i < WIN_LEN; i++) begin : g_merge
    always_comb begin
      mrg[i] = slot_q[i];
      for (int k = 0; k < NUM_TAPS; k++) begin
        if (wr_en[k] && valid_q[i] && (wr_pos[k*POS_W +: POS_W] == POS_W'(i)))
          mrg[i] = wr_data[k*ENT_W +: ENT_W];
      end
    end
    assign slot_flat[i*ENT_W +: ENT_W] = slot_q[i];
  end

  for (genvar i = 0; i < WIN_LEN - 1; i++) begin : g_shift
    assign slot_d[i]  = go ? mrg[i+1] : mrg[i];
    assign valid_d[i] = clear ? 1'b0 : (go ? valid_q[i+1] : valid_q[i]);
  end
  assign slot_d[WIN_LEN-1]  = go ? (zero_fill ? '0 : fill_data) : mrg[WIN_LEN-1];
  assign valid_d[WIN_LEN-1] = clear ? 1'b0 : (go ? enter_valid : valid_q[WIN_LEN-1]);

  assign bank_en = go || (|wr_en);

  always_ff @(posedge clk) begin
    if (bank_en) begin
      for (int i = 0; i < WIN_LEN; i++) slot_q[i] <= slot_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (go || clear) valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evict_we <= 1'b0;
    else        evict_we <= go && valid_q[0];
  end

  always_ff @(posedge clk) begin
    if (go) begin
      evict_addr <= depart_addr;
      evict_data <= mrg[0];
    end
  end

  assign slot_valid = valid_q;
endmodule

// File: rtl/llrwin_taps.sv
module llrwin_taps #(
  parameter int unsigned WIN_LEN  = 60,
  parameter int unsigned ENT_W    = 24,
  parameter int unsigned NUM_TAPS = 3,
  parameter int unsigned POS_W    = 6,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned LAG_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_open,
  input  logic                      cfg_we,
  input  logic [SEL_W-1:0]          cfg_sel,
  input  logic [POS_W-1:0]          cfg_off,
  input  logic [NUM_TAPS-1:0]       wb_en,
  input  logic [LAG_W-1:0]          wb_lag,
  input  logic [NUM_TAPS*ENT_W-1:0] wb_data,
  input  logic [WIN_LEN*ENT_W-1:0]  slot_flat,
  input  logic [WIN_LEN-1:0]        slot_valid,
  output logic [NUM_TAPS*ENT_W-1:0] tap_data,
  output logic [NUM_TAPS-1:0]       tap_valid,
  output logic [NUM_TAPS-1:0]       wr_en,
  output logic [NUM_TAPS*POS_W-1:0] wr_pos
);
  localparam logic [POS_W-1:0] WIN_POS = POS_W'(WIN_LEN - 1);

  logic [POS_W-1:0] off_q [NUM_TAPS];
  logic [POS_W-1:0] off_d [NUM_TAPS];
  logic             cfg_ok;

  assign cfg_ok = cfg_open && cfg_we && (cfg_off <= WIN_POS);

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_pos
    logic [POS_W:0] diff;
    logic           load;

    assign load     = cfg_ok && (cfg_sel == SEL_W'(k));
    assign off_d[k] = load ? cfg_off : off_q[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    off_q[k] <= POS_W'(k);
      else if (load) off_q[k] <= off_d[k];
    end

    // position of the tap's node after wb_lag shifts
    assign diff     = {1'b0, off_q[k]} - (POS_W+1)'(wb_lag);
    assign wr_en[k] = wb_en[k] && !diff[POS_W];
    assign wr_pos[k*POS_W +: POS_W] = diff[POS_W-1:0];
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_read
    logic [ENT_W-1:0] val;
    always_comb begin
      val = slot_flat[off_q[k]*ENT_W +: ENT_W];
      for (int j = 0; j < NUM_TAPS; j++) begin
        if (wr_en[j] && (wr_pos[j*POS_W +: POS_W] == off_q[k]))
          val = wb_data[j*ENT_W +: ENT_W];
      end
    end
    assign tap_valid[k] = slot_valid[off_q[k]];
    assign tap_data[k*ENT_W +: ENT_W] = tap_valid[k] ? val : '0;
  end
endmodule

// File: rtl/llr_window_cache.sv
module llr_window_cache #(
  parameter int unsigned WIN_LEN   = 60,
  parameter int unsigned FRAME_LEN = 1024,
  parameter int unsigned NUM_TAPS  = 3,
  parameter int unsigned NUM_LLR   = 3,
  parameter int unsigned LLR_W     = 8,
  parameter int unsigned PIPE_MAX  = 4,
  localparam int unsigned ENT_W    = NUM_LLR * LLR_W,
  localparam int unsigned POS_W    = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1,
  localparam int unsigned LAG_W    = $clog2(PIPE_MAX + 1),
  localparam int unsigned ADDR_W   = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1,
  localparam int unsigned SEL_W    = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [SEL_W-1:0]          cfg_sel,
  input  logic [POS_W-1:0]          cfg_off,
  input  logic                      start,
  input  logic                      first_pass,
  input  logic                      adv,
  output logic                      fill_rd,
  output logic [ADDR_W-1:0]         fill_addr,
  input  logic [ENT_W-1:0]          fill_data,
  output logic                      evict_we,
  output logic [ADDR_W-1:0]         evict_addr,
  output logic [ENT_W-1:0]          evict_data,
  output logic [NUM_TAPS*ENT_W-1:0] tap_data,
  output logic [NUM_TAPS-1:0]       tap_valid,
  input  logic [NUM_TAPS-1:0]       wb_en,
  input  logic [LAG_W-1:0]          wb_lag,
  input  logic [NUM_TAPS*ENT_W-1:0] wb_data,
  output logic                      busy
);
  localparam int unsigned IDX_W = $clog2(FRAME_LEN + WIN_LEN + 1);

  logic                      go, clear, enter_valid, zero_fill;
  logic [ADDR_W-1:0]         depart_addr;
  logic [WIN_LEN*ENT_W-1:0]  slot_flat;
  logic [WIN_LEN-1:0]        slot_valid;
  logic [NUM_TAPS-1:0]       wr_en;
  logic [NUM_TAPS*POS_W-1:0] wr_pos;

  llrwin_ctrl #(
    .WIN_LEN(WIN_LEN), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .first_pass(first_pass), .adv(adv),
    .busy(busy), .go(go), .clear(clear), .enter_valid(enter_valid),
    .zero_fill(zero_fill), .fill_rd(fill_rd), .fill_addr(fill_addr),
    .depart_addr(depart_addr)
  );

  llrwin_taps #(
    .WIN_LEN(WIN_LEN), .ENT_W(ENT_W), .NUM_TAPS(NUM_TAPS),
    .POS_W(POS_W), .SEL_W(SEL_W), .LAG_W(LAG_W)
  ) u_taps (
    .clk(clk), .rst_n(rst_n), .cfg_open(!busy), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_off(cfg_off), .wb_en(wb_en), .wb_lag(wb_lag),
    .wb_data(wb_data), .slot_flat(slot_flat), .slot_valid(slot_valid),
    .tap_data(tap_data), .tap_valid(tap_valid), .wr_en(wr_en), .wr_pos(wr_pos)
  );

  llrwin_bank #(
    .WIN_LEN(WIN_LEN), .ENT_W(ENT_W), .NUM_TAPS(NUM_TAPS),
    .POS_W(POS_W), .ADDR_W(ADDR_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .clear(clear), .go(go),
    .enter_valid(enter_valid), .zero_fill(zero_fill), .fill_data(fill_data),
    .wr_en(wr_en), .wr_pos(wr_pos), .wr_data(wb_data),
    .depart_addr(depart_addr), .slot_flat(slot_flat), .slot_valid(slot_valid),
    .evict_we(evict_we), .evict_addr(evict_addr), .evict_data(evict_data)
  );
endmodule

// File: rtl/llrwin_checks.sv
module llrwin_checks #(
  parameter int unsigned NUM_TAPS = 3,
  parameter int unsigned ADDR_W   = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                adv,
  input logic                busy,
  input logic                fill_rd,
  input logic [ADDR_W-1:0]   fill_addr,
  input logic                evict_we,
  input logic [ADDR_W-1:0]   evict_addr,
  input logic [NUM_TAPS-1:0] tap_valid
);
  // R2: memory is read only on an accepted advance
  a_r2_fill_needs_adv: assert property (@(posedge clk) disable iff (!rst_n)
    fill_rd |-> (adv && busy));

  // R2: back-to-back fetches walk the frame one node at a time
  a_r2_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_rd && $past(fill_rd)) |-> (fill_addr == $past(fill_addr) + 1'b1));

  // R4: nothing is present outside a pass
  a_r4_idle_absent: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tap_valid == '0));

  // R5: a write-back to memory follows an accepted advance
  a_r5_evict_after_adv: assert property (@(posedge clk) disable iff (!rst_n)
    evict_we |-> $past(adv && busy));

  // R5: consecutive departures carry consecutive node indices
  a_r5_evict_step: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_we && $past(evict_we)) |-> (evict_addr == $past(evict_addr) + 1'b1));

  // R9: a pass begins only on request
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R9: an idle window emits no write-back
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !evict_we);
endmodule

bind llr_window_cache llrwin_checks #(
  .NUM_TAPS(NUM_TAPS), .ADDR_W(ADDR_W)
) u_checks (
  .clk(clk), .rst_n(rst_n), .start(start), .adv(adv), .busy(busy),
  .fill_rd(fill_rd), .fill_addr(fill_addr), .evict_we(evict_we),
  .evict_addr(evict_addr), .tap_valid(tap_valid)
);

// File: tb/llr_window_cache_test.sv
module llr_window_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN  = 12;
  localparam int N    = 24;
  localparam int NT   = 3;
  localparam int NL   = 3;
  localparam int LW   = 8;
  localparam int PM   = 3;
  localparam int EW   = NL * LW;
  localparam int PW   = $clog2(WIN);
  localparam int LGW  = $clog2(PM + 1);
  localparam int AW   = $clog2(N);
  localparam int SW   = $clog2(NT);

  logic clk, rst_n;
  logic cfg_we;
  logic [SW-1:0] cfg_sel;
  logic [PW-1:0] cfg_off;
  logic start, first_pass, adv;
  logic fill_rd;
  logic [AW-1:0] fill_addr;
  logic [EW-1:0] fill_data;
  logic evict_we;
  logic [AW-1:0] evict_addr;
  logic [EW-1:0] evict_data;
  logic [NT*EW-1:0] tap_data;
  logic [NT-1:0] tap_valid;
  logic [NT-1:0] wb_en;
  logic [LGW-1:0] wb_lag;
  logic [NT*EW-1:0] wb_data;
  logic busy;

  llr_window_cache #(
    .WIN_LEN(WIN), .FRAME_LEN(N), .NUM_TAPS(NT), .NUM_LLR(NL),
    .LLR_W(LW), .PIPE_MAX(PM)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_off(cfg_off), .start(start), .first_pass(first_pass), .adv(adv),
    .fill_rd(fill_rd), .fill_addr(fill_addr), .fill_data(fill_data),
    .evict_we(evict_we), .evict_addr(evict_addr), .evict_data(evict_data),
    .tap_data(tap_data), .tap_valid(tap_valid), .wb_en(wb_en),
    .wb_lag(wb_lag), .wb_data(wb_data), .busy(busy)
  );

  // frame memory and behavioural model
  logic [EW-1:0] fmem  [N];
  logic [EW-1:0] ent_m [N];
  int  busy_m, nxt_m, first_m;
  int  off_m [NT];
  int  total, bad;
  string ph;

  assign fill_data = (int'(fill_addr) < N) ? fmem[fill_addr] : '0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit present(input int node);
    return (busy_m != 0) && node >= 0 && node < N;
  endfunction

  // one clock: called just after a falling edge with inputs driven
  task automatic run_cycle();
    int base, node, d;
    logic ev;
    logic [EW-1:0] ed;
    logic exp_fr, exp_ev;
    int exp_ea;
    logic [EW-1:0] exp_ed;
    base = nxt_m - WIN;
    #(CLK_PERIOD/4);
    for (int k = 0; k < NT; k++) begin
      node = base + off_m[k];
      ev = present(node);
      ed = '0;
      if (ev) begin
        ed = ent_m[node];
        for (int j = 0; j < NT; j++)
          if (wb_en[j] && off_m[j] >= int'(wb_lag) &&
              base + off_m[j] - int'(wb_lag) == node)
            ed = wb_data[j*EW +: EW];
      end
      chk({ph, " R3/R4 tap_valid"}, 64'(tap_valid[k]), 64'(ev));
      chk({ph, " R3/R6/R7 tap_data"}, 64'(tap_data[k*EW +: EW]), 64'(ed));
    end
    exp_fr = adv && (busy_m != 0) && nxt_m < N && (first_m == 0);
    chk({ph, " R2 fill_rd"}, 64'(fill_rd), 64'(exp_fr));
    if (exp_fr) chk({ph, " R2 fill_addr"}, 64'(fill_addr), 64'(nxt_m));

    @(posedge clk);
    exp_ev = 1'b0; exp_ea = 0; exp_ed = '0;
    if (busy_m != 0) begin
      for (int j = 0; j < NT; j++) begin
        if (wb_en[j] && off_m[j] >= int'(wb_lag)) begin
          node = base + off_m[j] - int'(wb_lag);
          if (present(node)) ent_m[node] = wb_data[j*EW +: EW];
        end
      end
      if (adv) begin
        d = base;
        if (d >= 0 && d < N) begin
          exp_ev = 1'b1; exp_ea = d; exp_ed = ent_m[d];
          fmem[d] = ent_m[d];
        end
        if (nxt_m < N) ent_m[nxt_m] = (first_m != 0) ? '0 : fmem[nxt_m];
        nxt_m++;
        if (nxt_m == N + WIN) busy_m = 0;
      end
    end else begin
      if (cfg_we && int'(cfg_off) < WIN) off_m[cfg_sel] = int'(cfg_off);
      if (start) begin
        busy_m = 1; nxt_m = 0; first_m = first_pass ? 1 : 0;
      end
    end
    #1;
    chk({ph, " R9 busy"}, 64'(busy), 64'(busy_m != 0));
    chk({ph, " R5 evict_we"}, 64'(evict_we), 64'(exp_ev));
    if (exp_ev) begin
      chk({ph, " R5 evict_addr"}, 64'(evict_addr), 64'(exp_ea));
      chk({ph, " R5 evict_data"}, 64'(evict_data), 64'(exp_ed));
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    cfg_we = 0; start = 0; adv = 0; wb_en = '0; wb_lag = '0;
  endtask

  task automatic rand_drive();
    int lag;
    adv = ($urandom % 4) != 0;
    lag = $urandom % (PM + 1);
    wb_lag = LGW'(lag);
    for (int k = 0; k < NT; k++) begin
      wb_en[k] = (($urandom % 2) != 0) && off_m[k] >= lag;
      wb_data[k*EW +: EW] = EW'($urandom);
    end
  endtask

  task automatic set_off(input int sel, input int off);
    cfg_we = 1; cfg_sel = SW'(sel); cfg_off = PW'(off);
    run_cycle();
    cfg_we = 0;
  endtask

  task automatic run_pass(input bit fp, input bit poke);
    int cnt;
    first_pass = fp; start = 1;
    run_cycle();
    start = 0;
    cnt = 0;
    while (busy_m != 0 && cnt < 400) begin
      rand_drive();
      if (poke && cnt == 15) begin
        ph = "R8 R9 busy poke";
        cfg_we = 1; cfg_sel = '0; cfg_off = PW'(3); start = 1;
      end
      run_cycle();
      if (poke && cnt == 15) ph = "R3 R4 R5 R6 R7 pass";
      cfg_we = 0; start = 0;
      cnt++;
    end
    quiet();
  endtask

  initial begin
    total = 0; bad = 0;
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    busy_m = 0; nxt_m = 0; first_m = 0;
    for (int k = 0; k < NT; k++) off_m[k] = k;
    for (int i = 0; i < N; i++) begin fmem[i] = '0; ent_m[i] = '0; end
    rst_n = 0; cfg_sel = '0; cfg_off = '0; first_pass = 0; wb_data = '0;
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    ph = "R1 reset";
    chk({ph, " busy"}, 64'(busy), 64'd0);
    chk({ph, " evict_we"}, 64'(evict_we), 64'd0);
    chk({ph, " tap_valid"}, 64'(tap_valid), 64'd0);
    chk({ph, " tap_data"}, 64'(tap_data), 64'd0);
    @(negedge clk);

    ph = "R9 idle adv";
    adv = 1;
    repeat (3) run_cycle();
    quiet();

    ph = "R1 default taps";
    run_pass(1'b1, 1'b0);

    ph = "R8 cfg idle";
    set_off(0, 0); set_off(1, 4); set_off(2, 11);
    ph = "R3 R4 R5 R6 R7 pass";
    run_pass(1'b1, 1'b1);

    ph = "R8 cfg range";
    set_off(0, 1); set_off(1, 6); set_off(2, 9);
    set_off(1, 13);
    ph = "R2 R6 R7 second pass";
    run_pass(1'b0, 1'b0);

    ph = "R2 third pass";
    set_off(1, 5);
    run_pass(1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule